// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a 32-bit word that records why the chip last came out of reset. Software can also use it to start a new reset. Five status flags sit in the top five bits of the word:

| Bit | Flag |
|-----|------|
| 31 | power-on |
| 30 | software power-on request |
| 29 | software warm-reset request |
| 28 | button power-on |
| 27 | button warm-reset |

Three of the flags are acknowledged by writing a one to them: bit 31, bit 28 and bit 27. The other two, bit 30 and bit 29, are set by writing a one to them. Setting either one raises a one-cycle system-reset request toward the reset controller.

The block counts the system resets it sees since power-up, in a saturating counter. This count decides whether the next reset is reported as a power-on. When the counter reads zero at a reset, the word is reloaded with only the power-on flag set. A software power-on request zeroes the counter, so the reset it causes is reported as a power-on. A software warm-reset request leaves the counter alone.

The register is the upper word (address bit 2 set) of an 8-byte window on a simple single-cycle register bus. Reads are combinational.

Top module: `rst_cause_reg`

## Requirements
- R1: After `pwr_rst_n` is released, the register reads 0x00000000, `reset_count` is 0 and `sys_rst_req` is low.
- R2: An access with `bus_addr[2]` = 0 reads 0 and a write to it changes neither the register, the count nor `sys_rst_req`.
- R3: Write data is masked to bits [31:27]. Writing 1 to bit 31, bit 28 or bit 27 clears that flag, and writing 0 to any of them leaves it unchanged.
- R4: Writing 1 to bit 30 or bit 29 sets that flag, and writing 0 leaves it unchanged. Bits [26:0] always read 0.
- R5: A write with bit 30 = 1 drives `sys_rst_req` high for exactly the one cycle after the write edge, and sets `reset_count` to 0 at that same edge.
- R6: A write with bit 29 = 1 and bit 30 = 0 drives the same one-cycle `sys_rst_req` pulse and leaves `reset_count` unchanged. A write with both bits 0 gives no pulse.
- R7: A reset event is a rising edge of `sys_rst`. If `reset_count` is 0 at that edge, the register becomes exactly 0x80000000; otherwise the register is unchanged. In both cases `reset_count` increments.
- R8: `reset_count` saturates at 2^CNT_W-1 instead of wrapping, so further resets never reload the power-on flag.
- R9: While `sys_rst` is high, bus writes are ignored (no flag change, no request, no count change). A `sys_rst` held for many cycles counts as one reset.
- R10: `bus_rdata` is 0 whenever `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Asynchronous power-up reset, active low |
| sys_rst | input | 1 | System reset level; its rising edge is a reset event |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte address within the window; bit 2 picks the upper word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sys_rst_req | output | 1 | One-cycle system-reset request |
| reset_count | output | CNT_W | Saturating count of reset events since power-up |

## Verification
Two things can land on the same clock edge: a system-reset event and a software write that would set a request flag or clear the counter. The bench forces this by raising `sys_rst` in the same cycle as a soft power-on write. It also holds `sys_rst` high across further writes.

Each case is judged at the ports, and the write must lose:
- The register must hold the reset-load value.
- `reset_count` must rise by exactly one.
- No request pulse may follow.

The bench then checks that the next write after release takes effect normally.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    localparam int REG_W    = 32;
    localparam int STAT_W   = 5;
    localparam int STAT_LSB = REG_W - STAT_W;

    // index of each flag inside the 5-bit status field (field bit 4 = word bit 31)
    localparam int F_PWR    = 4;
    localparam int F_SW_PWR = 3;
    localparam int F_SW_WRM = 2;
    localparam int F_BT_PWR = 1;
    localparam int F_BT_WRM = 0;

    localparam logic [STAT_W-1:0] CLR_MASK = 5'b10011;
    localparam logic [STAT_W-1:0] SET_MASK = 5'b01100;
    localparam logic [STAT_W-1:0] PWR_LOAD = 5'b10000;

    typedef struct packed {
        logic              hit;
        logic [STAT_W-1:0] bits;
    } wr_req_t;

endpackage

// File: rtl/rst_cause_bus.sv
module rst_cause_bus
    import rst_cause_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [STAT_W-1:0]    stat,
    output wr_req_t              wr,
    output logic [REG_W-1:0]     bus_rdata
);

    localparam int WORD_BIT = 2;

    logic upper_hit;

    always_comb begin
        upper_hit = bus_sel && bus_addr[WORD_BIT];
        wr.hit    = upper_hit && bus_we;
        wr.bits   = bus_wdata[REG_W-1:STAT_LSB];
        bus_rdata = '0;
        if (upper_hit) begin
            bus_rdata[REG_W-1:STAT_LSB] = stat;
        end
    end

endmodule

// File: rtl/rst_cause_ctr.sv
module rst_cause_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rst_cause_stat.sv
module rst_cause_stat
    import rst_cause_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  wr_req_t           wr,
    input  logic              cnt_zero,
    output logic [STAT_W-1:0] stat,
    output logic              req,
    output logic              ctr_clr,
    output logic              ctr_inc
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              req;
        logic              rst_prev;
    } state_t;

    state_t st_d, st_q;
    logic   rst_evt;
    logic   wr_live;

    always_comb begin
        st_d          = st_q;
        st_d.req      = 1'b0;
        st_d.rst_prev = sys_rst;
        rst_evt       = sys_rst && !st_q.rst_prev;
        wr_live       = wr.hit && !sys_rst;
        ctr_inc       = rst_evt;
        ctr_clr       = wr_live && wr.bits[F_SW_PWR];
        if (rst_evt) begin
            if (cnt_zero) st_d.stat = PWR_LOAD;
        end else if (wr_live) begin
            st_d.stat = (st_q.stat & ~(wr.bits & CLR_MASK)) | (wr.bits & SET_MASK);
            st_d.req  = wr.bits[F_SW_PWR] || wr.bits[F_SW_WRM];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign req  = st_q.req;

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_cause_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              pwr_rst_n,
    input  logic              sys_rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_req,
    output logic [CNT_W-1:0]  reset_count
);

    wr_req_t           wr;
    logic [STAT_W-1:0] stat_q;
    logic              ctr_clr;
    logic              ctr_inc;

    rst_cause_bus #(.ADDR_W(ADDR_W)) u_bus (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat      (stat_q),
        .wr        (wr),
        .bus_rdata (bus_rdata)
    );

    rst_cause_stat u_stat (
        .clk      (clk),
        .rst_n    (pwr_rst_n),
        .sys_rst  (sys_rst),
        .wr       (wr),
        .cnt_zero (reset_count == '0),
        .stat     (stat_q),
        .req      (sys_rst_req),
        .ctr_clr  (ctr_clr),
        .ctr_inc  (ctr_inc)
    );

    rst_cause_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (pwr_rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .cnt   (reset_count)
    );

endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              pwr_rst_n,
    input logic              sys_rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              sys_rst_req,
    input logic [CNT_W-1:0]  reset_count,
    input logic [4:0]        stat_q
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic prev_rst;
    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n) prev_rst <= 1'b0;
        else            prev_rst <= sys_rst;
    end

    logic evt, wr_ok;
    assign evt   = sys_rst && !prev_rst;
    assign wr_ok = bus_sel && bus_we && bus_addr[2] && !sys_rst;

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (!bus_sel || !bus_addr[2]) |-> bus_rdata == 32'd0);

    // R4
    rdata_pad_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        bus_rdata[26:0] == 27'd0);

    // R6
    req_cause_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr_ok && (bus_wdata[30] || bus_wdata[29])) |=> sys_rst_req);

    // R5
    req_only_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        !(wr_ok && (bus_wdata[30] || bus_wdata[29])) |=> !sys_rst_req);

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr_ok && bus_wdata[30]) |=> reset_count == '0);

    // R8
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (reset_count == CMAX && !(wr_ok && bus_wdata[30])) |=> reset_count == CMAX);

    // R7
    por_load_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (evt && reset_count == '0) |=> stat_q == 5'b10000);

    // R9
    hold_block_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (sys_rst && prev_rst) |=> ($stable(stat_q) && $stable(reset_count) && !sys_rst_req));

endmodule

bind rst_cause_reg rst_cause_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .pwr_rst_n   (pwr_rst_n),
    .sys_rst     (sys_rst),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_rst_req (sys_rst_req),
    .reset_count (reset_count),
    .stat_q      (stat_q)
);

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic              clk = 1'b0;
    logic              pwr_rst_n = 1'b0;
    logic              sys_rst = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              sys_rst_req;
    logic [CNT_W-1:0]  reset_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [4:0]       m_st  = '0;
    logic [CNT_W-1:0] m_cnt = '0;

    always #(CLK_P/2) clk = ~clk;

    rst_cause_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst(sys_rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_req(sys_rst_req), .reset_count(reset_count)
    );

    function automatic logic [4:0] f_wr(input logic [4:0] st, input logic [31:0] d);
        logic [4:0] m = d[31:27];
        return (st & ~(m & 5'b10011)) | (m & 5'b01100);
    endfunction

    function automatic logic [CNT_W-1:0] f_inc(input logic [CNT_W-1:0] c);
        return (c == CMAX) ? c : c + 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_upper(output logic [31:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'b100;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        @(negedge clk);
        rd_upper(v);
        chk({tag, " reg"}, v, {m_st, 27'd0});
        chk({tag, " cnt"}, 32'(reset_count), 32'(m_cnt));
        chk({tag, " req idle"}, 32'(sys_rst_req), 32'd0);
    endtask

    // one bus write; model updated unless sys_rst blocks it
    task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
        logic exp_req = 1'b0;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        if (!sys_rst && a[2]) begin
            m_st = f_wr(m_st, d);
            exp_req = d[30] | d[29];
            if (d[30]) m_cnt = '0;
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        chk({tag, " req pulse"}, 32'(sys_rst_req), 32'(exp_req));
    endtask

    task automatic rst_pulse(input int hold);
        @(negedge clk);
        sys_rst = 1'b1;
        if (m_cnt == '0) m_st = 5'b10000;
        m_cnt = f_inc(m_cnt);
        repeat (hold) @(negedge clk);
        sys_rst = 1'b0;
    endtask

    initial begin
        #(CLK_P*200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk-n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        pwr_rst_n = 1'b1;
        // R1
        check_state("R1 reset");

        // R7 first reset after power-up
        rst_pulse(1);
        check_state("R7 por load");

        // R2 lower word read zero, write ignored
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 3'b000; #1 chk("R2 low read", bus_rdata, 32'd0);
        bus_sel = 1'b0;
        wr("R2 low write", 3'b000, 32'hFFFF_FFFF);
        check_state("R2 after low write");

        // R10 unselected reads zero
        @(negedge clk);
        bus_addr = 3'b100; #1 chk("R10 unselected", bus_rdata, 32'd0);

        // R4 set flags, low bits never stick
        wr("R4 set warm", 3'b100, 32'h07FF_FFFF | 32'h2000_0000);
        check_state("R4 warm set");
        // R3 clear power-on flag; zero writes leave others
        wr("R3 clear pwr", 3'b100, 32'h8000_0000);
        check_state("R3 cleared");
        wr("R3 zero write", 3'b100, 32'h0000_0000);
        check_state("R3 unchanged");

        // R7 non-zero count: no reload
        rst_pulse(2);
        check_state("R7 no reload");

        // R5 soft power-on request
        wr("R5 soft por", 3'b100, 32'h4000_0000);
        check_state("R5 cnt cleared");
        rst_pulse(1);
        check_state("R5 reload after soft por");

        // R6 warm request keeps count
        wr("R6 warm", 3'b110, 32'h2000_0000);
        check_state("R6 cnt kept");

        // R9 collision: write on the reset edge and during hold
        @(negedge clk);
        sys_rst = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'b100;
        bus_wdata = 32'hF800_0000;
        if (m_cnt == '0) m_st = 5'b10000;
        m_cnt = f_inc(m_cnt);
        @(negedge clk);
        chk("R9 edge write req", 32'(sys_rst_req), 32'd0);
        bus_wdata = 32'h4000_0000;
        @(negedge clk);
        chk("R9 hold write req", 32'(sys_rst_req), 32'd0);
        bus_sel = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        sys_rst = 1'b0;
        check_state("R9 one count");
        wr("R9 after release", 3'b100, 32'h8000_0000);
        check_state("R9 write works");

        // R8 saturation
        for (int i = 0; i < 20; i++) rst_pulse(1);
        check_state("R8 saturated");
        wr("R8 clear pwr", 3'b100, 32'h8000_0000);
        rst_pulse(1);
        check_state("R8 no false por");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 6) begin
                logic [31:0] d = $urandom();
                if ($urandom_range(0, 3) != 0) d[30] = 1'b0;
                wr("R3 rnd write", 3'($urandom_range(0, 7)), d);
            end else if (op < 8) begin
                rst_pulse($urandom_range(1, 3));
            end
            check_state("R7 rnd state");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk-n_bad, n_chk);
        $finish;
    end

endmodule